// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block computes the memory address for halfword and signed-byte load/store operations. It also computes the value written back to the base register. A request carries five things: a base register value and its register index, the destination register index, an offset source and an addressing mode. The offset source is either a 9-bit signed immediate, or a register value paired with a subtract flag.

The block returns three results one clock after the request strobe: the transfer address, a writeback enable with the updated base value, and a flag that marks an encoding as illegal. The address arithmetic is combinational and feeds a single output register stage. Register file access, memory access and load data formatting are handled elsewhere.

A separate program-relative control forces the effective mode to pre-indexed without writeback and treats the base as the program counter register. In that case the supplied base value is taken to be the program counter value.

Top module: `lsag_unit`

## Requirements
- R1: Zero-offset mode (`mode` = 2'b00) gives a transfer address equal to the base, a writeback value equal to the base and no writeback. The offset inputs have no effect in this mode.
- R2: Pre-indexed mode (`mode` = 2'b01) gives a transfer address of base plus offset, and the writeback enable stays low.
- R3: Pre-indexed-with-writeback mode (`mode` = 2'b10) gives a transfer address of base plus offset and raises the writeback enable. The writeback value equals the transfer address.
- R4: Post-indexed mode (`mode` = 2'b11) uses the unmodified base as the transfer address and always requests writeback of base plus offset.
- R5: An immediate offset (`off_is_reg` = 0) is the 9-bit two's complement field sign-extended to 32 bits. The value -256 (9'h100) is outside the legal ±255 range and raises the illegal flag. `off_neg` has no effect on an immediate.
- R6: A register offset (`off_is_reg` = 1) is subtracted from the base when `off_neg` = 1 and added to it when `off_neg` = 0.
- R7: A writeback mode (2'b10 or 2'b11) whose effective base index is 15 raises the illegal flag.
- R8: A writeback mode whose destination index equals the effective base index raises the illegal flag.
- R9: With `pc_rel` = 1, `mode` and `base_idx` are ignored: the operation behaves as pre-indexed with base index 15 and no writeback. A register offset together with `pc_rel` raises the illegal flag.
- R10: An illegal request never enables writeback, but its transfer address and writeback value are still computed and reported.
- R11: Outputs appear on the cycle after the `req_valid` strobe. When `out_valid` is low, `out_wb_en` and `out_illegal` are low. Reset clears every output to zero.
- R12: Address arithmetic is modulo 2^32, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 2 | Addressing mode: 00 zero, 01 pre, 10 pre with writeback, 11 post |
| pc_rel | input | 1 | Program-relative form |
| base_val | input | 32 | Base register value |
| base_idx | input | 4 | Base register index |
| dest_idx | input | 4 | Destination register index |
| off_is_reg | input | 1 | 1 selects the register offset, 0 the immediate |
| imm_off | input | 9 | Signed immediate offset |
| reg_off | input | 32 | Register offset value |
| off_neg | input | 1 | Subtract the register offset |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Transfer address |
| out_wb_en | output | 1 | Base writeback enable |
| out_wb_val | output | 32 | New base value |
| out_illegal | output | 1 | Illegal encoding flag |

## Verification
Each request produces exactly one result, one cycle after the strobe, so a wrong internal decision shows on that single output beat and nowhere else. A swapped mode decode shows up as a transfer address that carries, or lacks, the offset. A wrong sign on the offset shows up as a wrong address or writeback value. A missed legality rule shows up as `out_wb_en` high next to a base index of 15 or a matching destination. Nothing carries over between requests, so no fault can stay hidden past that one beat.

// File: rtl/lsag_pkg.sv
`timescale 1ns/1ps
package lsag_pkg;

  typedef enum logic [1:0] {
    AM_ZERO   = 2'b00,
    AM_PRE    = 2'b01,
    AM_PRE_WB = 2'b10,
    AM_POST   = 2'b11
  } amode_e;

  function automatic logic mode_writes_back(input amode_e m);
    return (m == AM_PRE_WB) || (m == AM_POST);
  endfunction

  function automatic logic mode_uses_offset_addr(input amode_e m);
    return (m == AM_PRE) || (m == AM_PRE_WB);
  endfunction

endpackage

// File: rtl/lsag_offset.sv
`timescale 1ns/1ps
module lsag_offset #(
  parameter int AW      = 32,
  parameter int IMM_W   = 9,
  parameter int IMM_MAX = 255
) (
  input  logic             off_is_reg,
  input  logic [IMM_W-1:0] imm_off,
  input  logic [AW-1:0]    reg_off,
  input  logic             off_neg,
  output logic [AW-1:0]    delta,
  output logic             imm_bad
);
  localparam int EXT_W = AW - IMM_W;

  function automatic logic [AW-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [AW-1:0] signed_reg(input logic [AW-1:0] v, input logic neg);
    return neg ? (~v + {{(AW-1){1'b0}}, 1'b1}) : v;
  endfunction

  function automatic logic imm_in_range(input logic [IMM_W-1:0] v);
    logic signed [IMM_W:0] sv;
    sv = $signed({v[IMM_W-1], v});
    return (sv >= -IMM_MAX) && (sv <= IMM_MAX);
  endfunction

  logic [AW-1:0] imm_delta;
  logic [AW-1:0] reg_delta;

  assign imm_delta = sext_imm(imm_off);
  assign reg_delta = signed_reg(reg_off, off_neg);
  assign delta     = off_is_reg ? reg_delta : imm_delta;
  assign imm_bad   = !off_is_reg && !imm_in_range(imm_off);

endmodule

// File: rtl/lsag_rules.sv
`timescale 1ns/1ps
module lsag_rules
  import lsag_pkg::*;
#(
  parameter int RIW    = 4,
  parameter int PC_IDX = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  amode_e         eff_mode,
  input  logic [RIW-1:0] base_idx_eff,
  input  logic [RIW-1:0] dest_idx,
  input  logic           pc_rel,
  input  logic           off_is_reg,
  input  logic           imm_bad,
  output logic           illegal
);
  logic wb_req;
  logic bad_pc_base;
  logic bad_dest_clash;
  logic bad_pc_regoff;

  assign wb_req         = mode_writes_back(eff_mode);
  assign bad_pc_base    = wb_req && (base_idx_eff == RIW'(PC_IDX));
  assign bad_dest_clash = wb_req && (dest_idx == base_idx_eff);
  assign bad_pc_regoff  = pc_rel && off_is_reg;
  assign illegal        = bad_pc_base || bad_dest_clash || bad_pc_regoff || imm_bad;

  // R5: an out-of-range immediate must reach the illegal output
  a_r5_imm_range: assert property (@(posedge clk) disable iff (!rst_n)
    imm_bad |-> illegal);
  // R9: register offset with program-relative form is rejected
  a_r9_pcrel_regoff: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_rel && off_is_reg) |-> illegal);
  // R9: program-relative form never asks for writeback
  a_r9_pcrel_nowb: assert property (@(posedge clk) disable iff (!rst_n)
    pc_rel |-> !wb_req);

endmodule

// File: rtl/lsag_addr.sv
`timescale 1ns/1ps
module lsag_addr
  import lsag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  amode_e        eff_mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] delta,
  output logic [AW-1:0] xfer_addr,
  output logic [AW-1:0] wb_val,
  output logic          wb_want
);
  function automatic logic [AW-1:0] add_mod(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a + b;
  endfunction

  logic [AW-1:0] summed;

  assign summed    = add_mod(base_val, delta);
  assign xfer_addr = mode_uses_offset_addr(eff_mode) ? summed : base_val;
  assign wb_val    = (eff_mode == AM_ZERO) ? base_val : summed;
  assign wb_want   = mode_writes_back(eff_mode);

  // R3: pre-indexed writeback stores the very address used
  a_r3_pre_wb_same: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == AM_PRE_WB) |-> (xfer_addr == wb_val));
  // R1: zero offset leaves the base untouched and does not write back
  a_r1_zero_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == AM_ZERO) |-> (!wb_want && xfer_addr == base_val && wb_val == base_val));
  // R2: plain pre-indexed mode never writes back
  a_r2_pre_nowb: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == AM_PRE) |-> !wb_want);

endmodule

// File: rtl/lsag_unit.sv
`timescale 1ns/1ps
module lsag_unit
  import lsag_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IMM_W   = 9,
  parameter int IMM_MAX = 255,
  parameter int RIW     = 4,
  parameter int PC_IDX  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       mode,
  input  logic             pc_rel,
  input  logic [AW-1:0]    base_val,
  input  logic [RIW-1:0]   base_idx,
  input  logic [RIW-1:0]   dest_idx,
  input  logic             off_is_reg,
  input  logic [IMM_W-1:0] imm_off,
  input  logic [AW-1:0]    reg_off,
  input  logic             off_neg,
  output logic             out_valid,
  output logic [AW-1:0]    out_addr,
  output logic             out_wb_en,
  output logic [AW-1:0]    out_wb_val,
  output logic             out_illegal
);
  amode_e         eff_mode;
  logic [RIW-1:0] base_idx_eff;
  logic [AW-1:0]  delta;
  logic           imm_bad;
  logic           illegal;
  logic [AW-1:0]  xfer_addr;
  logic [AW-1:0]  wb_val;
  logic           wb_want;
  logic           wb_grant;

  assign eff_mode     = pc_rel ? AM_PRE : amode_e'(mode);
  assign base_idx_eff = pc_rel ? RIW'(PC_IDX) : base_idx;

  lsag_offset #(.AW(AW), .IMM_W(IMM_W), .IMM_MAX(IMM_MAX)) u_offset (
    .off_is_reg (off_is_reg),
    .imm_off    (imm_off),
    .reg_off    (reg_off),
    .off_neg    (off_neg),
    .delta      (delta),
    .imm_bad    (imm_bad)
  );

  lsag_rules #(.RIW(RIW), .PC_IDX(PC_IDX)) u_rules (
    .clk          (clk),
    .rst_n        (rst_n),
    .eff_mode     (eff_mode),
    .base_idx_eff (base_idx_eff),
    .dest_idx     (dest_idx),
    .pc_rel       (pc_rel),
    .off_is_reg   (off_is_reg),
    .imm_bad      (imm_bad),
    .illegal      (illegal)
  );

  lsag_addr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .eff_mode  (eff_mode),
    .base_val  (base_val),
    .delta     (delta),
    .xfer_addr (xfer_addr),
    .wb_val    (wb_val),
    .wb_want   (wb_want)
  );

  assign wb_grant = wb_want && !illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_wb_en   <= 1'b0;
      out_wb_val  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= req_valid;
      out_wb_en   <= req_valid && wb_grant;
      out_illegal <= req_valid && illegal;
      if (req_valid) begin
        out_addr   <= xfer_addr;
        out_wb_val <= wb_val;
      end
    end
  end

  // R11: one-cycle latency and quiet flags when idle
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_wb_en && !out_illegal));
  // R10: illegal results never write back
  a_r10_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_wb_en);
  // R4: post-indexed transfer uses the unmodified base
  a_r4_post_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pc_rel && mode == 2'b11) |=> (out_addr == $past(base_val)));
  // R7: base register 15 never receives a writeback
  a_r7_pc_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && base_idx == RIW'(PC_IDX)) |=> !out_wb_en);
  // R8: destination equal to base never receives a writeback
  a_r8_dest_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dest_idx == base_idx) |=> !out_wb_en);
  // R9: program-relative requests never write back
  a_r9_pcrel_out: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pc_rel) |=> !out_wb_en);

endmodule

// File: tb/lsag_unit_test.sv
`timescale 1ns/1ps
module lsag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic        pc_rel = 1'b0;
  logic [31:0] base_val = '0;
  logic [3:0]  base_idx = '0;
  logic [3:0]  dest_idx = '0;
  logic        off_is_reg = 1'b0;
  logic [8:0]  imm_off = '0;
  logic [31:0] reg_off = '0;
  logic        off_neg = 1'b0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_wb_en;
  logic [31:0] out_wb_val;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lsag_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .pc_rel(pc_rel),
    .base_val(base_val), .base_idx(base_idx), .dest_idx(dest_idx),
    .off_is_reg(off_is_reg), .imm_off(imm_off), .reg_off(reg_off), .off_neg(off_neg),
    .out_valid(out_valid), .out_addr(out_addr), .out_wb_en(out_wb_en),
    .out_wb_val(out_wb_val), .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Expected results restated from the requirements
  task automatic model(output logic [31:0] ea, output logic ew, output logic [31:0] ev, output logic ei);
    logic [31:0] off;
    logic [1:0]  m;
    logic [3:0]  bx;
    logic        wbw;
    off = off_is_reg ? (off_neg ? (32'd0 - reg_off) : reg_off) : {{23{imm_off[8]}}, imm_off};
    m   = pc_rel ? 2'b01 : mode;
    bx  = pc_rel ? 4'd15 : base_idx;
    wbw = (m == 2'b10) || (m == 2'b11);
    ei  = (wbw && bx == 4'd15) || (wbw && dest_idx == bx) ||
          (!off_is_reg && imm_off == 9'h100) || (pc_rel && off_is_reg);
    ea  = (m == 2'b00 || m == 2'b11) ? base_val : base_val + off;
    ev  = (m == 2'b00) ? base_val : base_val + off;
    ew  = wbw && !ei;
  endtask

  // Inputs are set at a falling edge; the result is read at the next one
  task automatic run(input string tag);
    logic [31:0] ea, ev;
    logic ew, ei;
    model(ea, ew, ev, ei);
    req_valid = 1'b1;
    @(negedge clk);
    chk(tag, "valid", {31'd0, out_valid}, 32'd1);
    chk(tag, "addr", out_addr, ea);
    chk(tag, "wb_en", {31'd0, out_wb_en}, {31'd0, ew});
    chk(tag, "wb_val", out_wb_val, ev);
    chk(tag, "illegal", {31'd0, out_illegal}, {31'd0, ei});
  endtask

  task automatic setreq(input logic [1:0] m, input logic pr, input logic [31:0] b,
                        input logic [3:0] bi, input logic [3:0] di, input logic isr,
                        input logic [8:0] im, input logic [31:0] rv, input logic ng);
    mode = m; pc_rel = pr; base_val = b; base_idx = bi; dest_idx = di;
    off_is_reg = isr; imm_off = im; reg_off = rv; off_neg = ng;
  endtask

  initial begin
    #1200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset valid", {31'd0, out_valid}, 32'd0);
    chk("R11", "reset addr", out_addr, 32'd0);
    chk("R11", "reset wb_val", out_wb_val, 32'd0);
    chk("R11", "reset flags", {30'd0, out_wb_en, out_illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: zero offset ignores a non-zero offset
    setreq(2'b00, 0, 32'h0000_1000, 4'd2, 4'd3, 0, 9'd22, 32'h0, 0);   run("R1");
    setreq(2'b00, 0, 32'h0000_1000, 4'd2, 4'd3, 1, 9'd0, 32'h44, 1);   run("R1");
    // R2: pre-indexed immediate
    setreq(2'b01, 0, 32'h0000_2000, 4'd0, 4'd1, 0, 9'd22, 32'h0, 0);   run("R2");
    // R3: pre-indexed with writeback, register offset
    setreq(2'b10, 0, 32'h0000_3000, 4'd0, 4'd4, 1, 9'd0, 32'h10, 0);   run("R3");
    // R4: post-indexed with negative immediate
    setreq(2'b11, 0, 32'h0000_4000, 4'd5, 4'd6, 0, 9'h1F0, 32'h0, 0);  run("R4");
    // R5: -256 is illegal, -255 is legal, off_neg ignored for immediates
    setreq(2'b10, 0, 32'h0000_5000, 4'd1, 4'd2, 0, 9'h100, 32'h0, 0);  run("R5");
    setreq(2'b10, 0, 32'h0000_5000, 4'd1, 4'd2, 0, 9'h101, 32'h0, 0);  run("R5");
    setreq(2'b01, 0, 32'h0000_5000, 4'd1, 4'd2, 0, 9'd255, 32'h0, 1);  run("R5");
    chk("R5", "imm +255 neg ignored", out_addr, 32'h0000_50FF);
    // R6: register offset subtraction
    setreq(2'b01, 0, 32'h0000_6000, 4'd1, 4'd2, 1, 9'd0, 32'h30, 1);   run("R6");
    chk("R6", "sub addr", out_addr, 32'h0000_5FD0);
    // R7: base 15 with writeback
    setreq(2'b11, 0, 32'h0000_7000, 4'd15, 4'd2, 0, 9'd4, 32'h0, 0);   run("R7");
    chk("R7", "illegal", {31'd0, out_illegal}, 32'd1);
    // R8: destination equals base
    setreq(2'b10, 0, 32'h0000_8000, 4'd3, 4'd3, 0, 9'd4, 32'h0, 0);    run("R8");
    chk("R8", "illegal", {31'd0, out_illegal}, 32'd1);
    setreq(2'b01, 0, 32'h0000_8000, 4'd3, 4'd3, 0, 9'd4, 32'h0, 0);    run("R8");
    // R9: program-relative ignores mode and base index
    setreq(2'b11, 1, 32'h0000_9000, 4'd3, 4'd7, 0, 9'd8, 32'h0, 0);    run("R9");
    chk("R9", "pc addr", out_addr, 32'h0000_9008);
    setreq(2'b01, 1, 32'h0000_9000, 4'd3, 4'd7, 1, 9'd0, 32'h8, 0);    run("R9");
    // R10: illegal still reports address and writeback value
    setreq(2'b11, 0, 32'h0000_A000, 4'd4, 4'd4, 0, 9'd16, 32'h0, 0);   run("R10");
    chk("R10", "wb_val", out_wb_val, 32'h0000_A010);
    // R12: modulo wrap
    setreq(2'b10, 0, 32'hFFFF_FFF0, 4'd1, 4'd2, 0, 9'd32, 32'h0, 0);   run("R12");
    chk("R12", "wrap", out_addr, 32'h0000_0010);
    setreq(2'b01, 0, 32'h0000_0004, 4'd1, 4'd2, 1, 9'd0, 32'h8, 1);    run("R12");

    // R11: idle cycle drops the flags
    setreq(2'b10, 0, 32'h0, 4'd1, 4'd2, 0, 9'd4, 32'h0, 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11", "idle valid", {31'd0, out_valid}, 32'd0);
    chk("R11", "idle flags", {30'd0, out_wb_en, out_illegal}, 32'd0);

    // Random mix across all modes
    for (int i = 0; i < 500; i++) begin
      setreq(2'($urandom), ($urandom % 8) == 0, $urandom, 4'($urandom), 4'($urandom),
             1'($urandom), 9'($urandom), $urandom, 1'($urandom));
      if (pc_rel) run("R9");
      else case (mode)
        2'b00: run("R1");
        2'b01: run("R2");
        2'b10: run("R3");
        default: run("R4");
      endcase
    end

    req_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule